// File: doc/BRIEF.md
# Transfer-Complete Interrupt Mode Generator

This block sits beside a multi-channel DMA engine and converts its per-channel transmit and receive completion strobes into interrupt signalling. Each channel and direction has a latched status bit that software clears by writing one. There is a separate interrupt line for each channel's transmit side and for its receive side, plus one common line that merges all of them under a global enable.

A stored 2-bit mode value selects the signalling style. In pulse style, every completion gives a single-cycle pulse. In level style, each line mirrors its status bit gated by its enable. In queued style, completions that arrive while the status bit is already set are counted, and clearing the bit leaves it set again until that backlog is drained, so software never misses a completion.

Top module: `dma_cmpl_irq_top`

## Requirements
- R1: During and after a synchronous reset, all status bits, all interrupt lines and the common line are 0, and the stored mode reads 1.
- R2: In mode 0, an event on an enabled channel and direction drives that channel's interrupt line high for exactly the one cycle after the event. Events in consecutive cycles give consecutive high cycles, and the line is low in the cycle after the last event even while the status bit stays set.
- R3: In mode 1, each per-channel interrupt line equals its status bit ANDed with its enable bit, and it changes in the same cycle as the status bit.
- R4: A status bit becomes 1 in the cycle after an event. A clear strobe on a set bit with no pending events makes it 0 in the next cycle. When an event and a clear arrive in the same cycle, the bit stays or becomes 1.
- R5: In mode 2, an event without a clear, arriving while the status bit is set, adds one to a 4-bit pending count that saturates at 15. A clear while the count is nonzero subtracts one and keeps the status bit set. Interrupt lines follow status AND enable, as in mode 1.
- R6: In mode 2, an event and a clear in the same cycle leave the pending count unchanged.
- R7: The common line equals the global enable ANDed with the OR of all per-channel transmit and receive interrupt lines, in the same cycle as those lines.
- R8: The reserved mode value 3 is stored as written and behaves exactly like mode 1.
- R9: A mode write whose value differs from the stored mode sets every pending count to 0 and leaves the status bits unchanged.
- R10: The stored mode shown on `mode_o` takes the written value in the cycle after the mode write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_we_i | input | 1 | Mode write strobe |
| mode_wd_i | input | 2 | Mode write value (0 pulse, 1 level, 2 queued, 3 as 1) |
| glb_ie_i | input | 1 | Global enable for the common line |
| tx_ie_i | input | NUM_CH | Per-channel transmit interrupt enables |
| rx_ie_i | input | NUM_CH | Per-channel receive interrupt enables |
| tx_evt_i | input | NUM_CH | Transmit completion strobes |
| rx_evt_i | input | NUM_CH | Receive completion strobes |
| tx_clr_i | input | NUM_CH | Write-one-to-clear strobes for transmit status |
| rx_clr_i | input | NUM_CH | Write-one-to-clear strobes for receive status |
| mode_o | output | 2 | Stored mode value |
| tx_sts_o | output | NUM_CH | Transmit status bits |
| rx_sts_o | output | NUM_CH | Receive status bits |
| tx_irq_o | output | NUM_CH | Per-channel transmit interrupt lines |
| rx_irq_o | output | NUM_CH | Per-channel receive interrupt lines |
| com_irq_o | output | 1 | Common interrupt line |

## Verification
The pending counters are hidden, so an error in them only becomes visible when clears arrive. A count that is too high keeps a status bit set for extra clear cycles. A count that is too low, or a wrong reset on a mode change, drops the bit early, and this shows at the port in the cycle after the offending clear. The bench therefore drains every backlog one clear at a time and compares status and interrupt lines against a reference model every cycle, so a wrong count is reported at the first clear where the bit should differ. A wrong mode decode shows at once on the next event as a missing pulse or a line that stays high.

// File: rtl/dma_cmpl_irq_pkg.sv
package dma_cmpl_irq_pkg;
  typedef enum logic [1:0] {
    MODE_PULSE = 2'd0,
    MODE_LEVEL = 2'd1,
    MODE_QUEUE = 2'd2,
    MODE_RSVD  = 2'd3
  } irq_mode_t;

  // The reserved code is treated as level mode.
  function automatic irq_mode_t eff_mode(input logic [1:0] raw);
    return (raw == 2'd3) ? MODE_LEVEL : irq_mode_t'(raw);
  endfunction
endpackage

// File: rtl/dma_cmpl_irq_cell.sv
module dma_cmpl_irq_cell
  import dma_cmpl_irq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic      clk_i,
  input  logic      rst_i,
  input  irq_mode_t mode_i,
  input  logic      mode_chg_i,
  input  logic      evt_i,
  input  logic      clr_i,
  input  logic      ie_i,
  output logic      sts_o,
  output logic      irq_o,
  output logic      irq_nxt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             sts_q, sts_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;

  always_comb begin
    sts_d = sts_q;
    cnt_d = cnt_q;
    if (evt_i) begin
      sts_d = 1'b1;
      if (!clr_i && sts_q && mode_i == MODE_QUEUE && cnt_q != CNT_MAX)
        cnt_d = cnt_q + 1'b1;
    end else if (clr_i && sts_q) begin
      if (mode_i == MODE_QUEUE && cnt_q != '0) cnt_d = cnt_q - 1'b1;
      else                                      sts_d = 1'b0;
    end
    if (mode_chg_i) cnt_d = '0;
    irq_d = (mode_i == MODE_PULSE) ? (evt_i & ie_i) : (sts_d & ie_i);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sts_q <= 1'b0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign sts_o     = sts_q;
  assign irq_o     = irq_q;
  assign irq_nxt_o = irq_d;

  p_pulse_src_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_o && $past(mode_i) == MODE_PULSE) |-> $past(evt_i && ie_i));
  p_level_follow_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(mode_i) != MODE_PULSE) |-> (irq_o == (sts_o && $past(ie_i))));
  p_evt_sets_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    evt_i |=> sts_o);
  p_clr_drops_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !evt_i && sts_o && cnt_q == '0) |=> !sts_o);
  p_pend_needs_sts_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q != '0) |-> sts_o);
  p_mode_chg_zero_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    mode_chg_i |=> (cnt_q == '0));
endmodule

// File: rtl/dma_cmpl_irq_top.sv
module dma_cmpl_irq_top
  import dma_cmpl_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              mode_we_i,
  input  logic [1:0]        mode_wd_i,
  input  logic              glb_ie_i,
  input  logic [NUM_CH-1:0] tx_ie_i,
  input  logic [NUM_CH-1:0] rx_ie_i,
  input  logic [NUM_CH-1:0] tx_evt_i,
  input  logic [NUM_CH-1:0] rx_evt_i,
  input  logic [NUM_CH-1:0] tx_clr_i,
  input  logic [NUM_CH-1:0] rx_clr_i,
  output logic [1:0]        mode_o,
  output logic [NUM_CH-1:0] tx_sts_o,
  output logic [NUM_CH-1:0] rx_sts_o,
  output logic [NUM_CH-1:0] tx_irq_o,
  output logic [NUM_CH-1:0] rx_irq_o,
  output logic              com_irq_o
);
  localparam int NUM_LINES = 2 * NUM_CH;

  logic [1:0]           mode_q;
  irq_mode_t            mode_eff;
  logic                 mode_chg;
  logic [NUM_LINES-1:0] evt_v, clr_v, ie_v, sts_v, irq_v, irq_nxt_v;
  logic                 com_q;

  assign mode_eff = eff_mode(mode_q);
  assign mode_chg = mode_we_i && (mode_wd_i != mode_q);

  always_ff @(posedge clk_i) begin
    if (rst_i)          mode_q <= 2'd1;
    else if (mode_we_i) mode_q <= mode_wd_i;
  end

  // Lines 0..NUM_CH-1 are transmit, NUM_CH..2*NUM_CH-1 are receive.
  assign evt_v = {rx_evt_i, tx_evt_i};
  assign clr_v = {rx_clr_i, tx_clr_i};
  assign ie_v  = {rx_ie_i,  tx_ie_i};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    dma_cmpl_irq_cell #(.CNT_W(CNT_W)) cell_i (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .mode_i    (mode_eff),
      .mode_chg_i(mode_chg),
      .evt_i     (evt_v[g]),
      .clr_i     (clr_v[g]),
      .ie_i      (ie_v[g]),
      .sts_o     (sts_v[g]),
      .irq_o     (irq_v[g]),
      .irq_nxt_o (irq_nxt_v[g])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) com_q <= 1'b0;
    else       com_q <= glb_ie_i && (|irq_nxt_v);
  end

  assign mode_o    = mode_q;
  assign tx_sts_o  = sts_v[NUM_CH-1:0];
  assign rx_sts_o  = sts_v[NUM_LINES-1:NUM_CH];
  assign tx_irq_o  = irq_v[NUM_CH-1:0];
  assign rx_irq_o  = irq_v[NUM_LINES-1:NUM_CH];
  assign com_irq_o = com_q;

  p_com_has_src_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    com_irq_o |-> (|{tx_irq_o, rx_irq_o}));
  p_com_gate_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(glb_ie_i) |-> !com_irq_o);
  p_mode_store_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    mode_we_i |=> (mode_o == $past(mode_wd_i)));
endmodule

// File: tb/dma_cmpl_irq_top_tb_top.sv
module dma_cmpl_irq_top_tb_top;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic           mode_we = 1'b0, glb_ie = 1'b0;
  logic [1:0]     mode_wd = 2'd0;
  logic [NCH-1:0] tx_ie = '0, rx_ie = '0, tx_evt = '0, rx_evt = '0, tx_clr = '0, rx_clr = '0;
  logic [1:0]     mode_o;
  logic [NCH-1:0] tx_sts, rx_sts, tx_irq, rx_irq;
  logic           com_irq;

  dma_cmpl_irq_top #(.NUM_CH(NCH), .CNT_W(4)) dut_i (
    .clk_i(clk), .rst_i(rst), .mode_we_i(mode_we), .mode_wd_i(mode_wd),
    .glb_ie_i(glb_ie), .tx_ie_i(tx_ie), .rx_ie_i(rx_ie),
    .tx_evt_i(tx_evt), .rx_evt_i(rx_evt), .tx_clr_i(tx_clr), .rx_clr_i(rx_clr),
    .mode_o(mode_o), .tx_sts_o(tx_sts), .rx_sts_o(rx_sts),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq), .com_irq_o(com_irq)
  );

  int n_run = 0, n_fail = 0;

  // Reference model
  logic [1:0]     m_mode = 2'd1;
  logic [NCH-1:0] m_sts [2];
  int             m_cnt [2][NCH];
  logic [NCH-1:0] e_irq [2];
  logic           e_com;
  string          irq_tag;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic model_step();
    logic chg;
    logic [1:0] em;
    logic ev, cl, ie;
    chg = mode_we && (mode_wd != m_mode);
    em  = (m_mode == 2'd3) ? 2'd1 : m_mode;
    irq_tag = tag_of(m_mode);
    e_com = 1'b0;
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < NCH; c++) begin
        ev = d ? rx_evt[c] : tx_evt[c];
        cl = d ? rx_clr[c] : tx_clr[c];
        ie = d ? rx_ie[c]  : tx_ie[c];
        if (ev) begin
          if (!cl && m_sts[d][c] && em == 2'd2 && m_cnt[d][c] < 15) m_cnt[d][c]++;
          m_sts[d][c] = 1'b1;
        end else if (cl && m_sts[d][c]) begin
          if (em == 2'd2 && m_cnt[d][c] > 0) m_cnt[d][c]--;
          else m_sts[d][c] = 1'b0;
        end
        if (chg) m_cnt[d][c] = 0;
        e_irq[d][c] = (em == 2'd0) ? (ev & ie) : (m_sts[d][c] & ie);
        e_com |= e_irq[d][c];
      end
    end
    e_com &= glb_ie;
    if (mode_we) m_mode = mode_wd;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    chk("R4 tx status", 32'(tx_sts), 32'(m_sts[0]));
    chk("R4 rx status", 32'(rx_sts), 32'(m_sts[1]));
    chk({irq_tag, " tx irq"}, 32'(tx_irq), 32'(e_irq[0]));
    chk({irq_tag, " rx irq"}, 32'(rx_irq), 32'(e_irq[1]));
    chk("R7 common", 32'(com_irq), 32'(e_com));
    chk("R10 mode", 32'(mode_o), 32'(m_mode));
    tx_evt = '0; rx_evt = '0; tx_clr = '0; rx_clr = '0; mode_we = 1'b0;
  endtask

  task automatic wr_mode(input logic [1:0] v);
    mode_we = 1'b1; mode_wd = v; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_sts[0] = '0; m_sts[1] = '0;
    for (int d = 0; d < 2; d++) for (int c = 0; c < NCH; c++) m_cnt[d][c] = 0;
    tx_evt = '1; rx_evt = '1; tx_ie = '1; rx_ie = '1; glb_ie = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs held at reset values despite active inputs
    chk("R1 sts", 32'({tx_sts, rx_sts}), 32'h0);
    chk("R1 irq", 32'({tx_irq, rx_irq, com_irq}), 32'h0);
    chk("R1 mode", 32'(mode_o), 32'd1);
    tx_evt = '0; rx_evt = '0;
    rst = 1'b0;
    @(negedge clk);

    // R3 level mode
    tx_evt[0] = 1'b1; tick();
    chk("R3 level high", 32'(tx_irq[0]), 32'd1);
    tx_clr[0] = 1'b1; tick();
    chk("R4 cleared", 32'(tx_sts[0]), 32'd0);

    // R2 pulse mode, back-to-back events
    wr_mode(2'd0);
    repeat (3) begin rx_evt[1] = 1'b1; tick(); chk("R2 pulse", 32'(rx_irq[1]), 32'd1); end
    tick();
    chk("R2 pulse ends", 32'(rx_irq[1]), 32'd0);
    chk("R2 status kept", 32'(rx_sts[1]), 32'd1);
    rx_clr[1] = 1'b1; tick();

    // R5 queued mode: three extra events, drained by clears
    wr_mode(2'd2);
    repeat (4) begin tx_evt[2] = 1'b1; tick(); end
    repeat (3) begin tx_clr[2] = 1'b1; tick(); chk("R5 requeued", 32'(tx_sts[2]), 32'd1); end
    tx_clr[2] = 1'b1; tick();
    chk("R5 drained", 32'(tx_sts[2]), 32'd0);

    // R6 event+clear same cycle leaves count unchanged
    tx_evt[2] = 1'b1; tick();
    tx_evt[2] = 1'b1; tx_clr[2] = 1'b1; tick();
    chk("R6 event wins", 32'(tx_sts[2]), 32'd1);
    tx_clr[2] = 1'b1; tick();
    chk("R6 count unchanged", 32'(tx_sts[2]), 32'd0);

    // R5 saturation at 15
    repeat (20) begin rx_evt[3] = 1'b1; tick(); end
    repeat (15) begin rx_clr[3] = 1'b1; tick(); end
    chk("R5 sat held", 32'(rx_sts[3]), 32'd1);
    rx_clr[3] = 1'b1; tick();
    chk("R5 sat drained", 32'(rx_sts[3]), 32'd0);

    // R9 mode change clears counts, keeps status
    repeat (3) begin tx_evt[1] = 1'b1; tick(); end
    wr_mode(2'd1);
    wr_mode(2'd2);
    chk("R9 status kept", 32'(tx_sts[1]), 32'd1);
    tx_clr[1] = 1'b1; tick();
    chk("R9 count zeroed", 32'(tx_sts[1]), 32'd0);

    // R8 reserved mode
    wr_mode(2'd3);
    chk("R8 mode stored", 32'(mode_o), 32'd3);
    rx_evt[0] = 1'b1; tick(); tick();
    chk("R8 level held", 32'(rx_irq[0]), 32'd1);

    // R7 global gate
    glb_ie = 1'b0; tick();
    chk("R7 gated", 32'(com_irq), 32'd0);
    glb_ie = 1'b1; tick();
    chk("R7 ungated", 32'(com_irq), 32'd1);

    // Random phase
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4000; i++) begin
      tx_evt = NCH'($urandom & $urandom);
      rx_evt = NCH'($urandom & $urandom);
      tx_clr = NCH'($urandom & $urandom);
      rx_clr = NCH'($urandom & $urandom);
      if ($urandom_range(0, 15) == 0) begin tx_ie = NCH'($urandom); rx_ie = NCH'($urandom); end
      if ($urandom_range(0, 31) == 0) glb_ie = 1'($urandom);
      if ($urandom_range(0, 63) == 0) begin mode_we = 1'b1; mode_wd = 2'($urandom); end
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule